// File: doc/BRIEF.md
# Three-Wire Serial Control Register Port

This block receives write-only configuration frames over three slow wires: a serial data line, a bit clock and a latch strobe. All three come from a host and have no fixed phase to the system clock. They pass through synchronizer flops, and the edges are found in the system clock domain. A 16-bit shift register collects the data MSB first. A rising edge on the latch strobe commits the payload to one of three registers: left volume, right volume or control.

The two address bits sit at the bottom of each frame, so they arrive last. The upper fourteen bits are the payload. The control register is split into named fields. The serial-format, mute, 4x-rate and 2x-rate fields are ORed with external pins, so that either the host or the board wiring can set them.

An asynchronous hardware reset returns the volumes to full scale and clears the control register. The soft-reset control bit only raises a hold output. It leaves every stored value in place, and clearing the bit lets normal operation resume.

Top module: `ctl3w_regfile`

## Requirements
- R1: While `rst_n` is low, both volume outputs read 14'h3FFF and every control-derived output reads 0, with all pins low.
- R2: A frame is shifted in MSB first, one bit per rising edge of `ser_clk`. On a latch rise with frame bits [1:0] = 00, frame bits [15:2] become `vol_l`.
- R3: On a latch rise with frame bits [1:0] = 10, frame bits [15:2] become `vol_r`.
- R4: On a latch rise with frame bits [1:0] = 01, the control register loads its fields from frame bit positions:
  - de-emphasis select at [3:2]
  - serial format at [5:4]
  - soft mute at [6]
  - soft reset at [7]
  - word length at [9:8]
  - 4x rate at [10]
  - 2x rate at [11]
- R5: On a latch rise with frame bits [1:0] = 11, no output changes.
- R6: `fmt_eff`, `mute_eff`, `x4_eff` and `x2_eff` are the bitwise OR of the stored field and `pin_fmt`, `pin_mute`, `pin_x4` and `pin_x2` respectively.
- R7: The soft-reset field drives `op_hold` high. While it is set, the volume contents and the other control fields keep their values. Writing it back to 0 clears `op_hold`.
- R8: Shifting bits without a latch rise leaves every register output unchanged.
- R9: A register output takes its new value on the third rising system-clock edge at which `ser_lat` is sampled high. This assumes that at least four system clocks separate the last `ser_clk` rise from the latch rise.
- R10: When more than 16 bits are shifted before a latch, only the last 16 bits form the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_dat | input | 1 | Serial data, MSB first |
| ser_lat | input | 1 | Commit strobe, rising-edge active |
| pin_fmt | input | 2 | Board pins ORed into the serial format field |
| pin_mute | input | 1 | Board pin ORed into soft mute |
| pin_x4 | input | 1 | Board pin ORed into the 4x-rate field |
| pin_x2 | input | 1 | Board pin ORed into the 2x-rate field |
| vol_l | output | 14 | Left volume register |
| vol_r | output | 14 | Right volume register |
| demph_sel | output | 2 | De-emphasis select field |
| fmt_eff | output | 2 | Effective serial format |
| mute_eff | output | 1 | Effective mute |
| word_len | output | 2 | Right-justified word length field |
| x4_eff | output | 1 | Effective 4x-rate select |
| x2_eff | output | 1 | Effective 2x-rate select |
| op_hold | output | 1 | Soft reset: normal operation suspended |

## Verification
Each serial input change first appears in the system domain two clocks later. The edge it causes acts on the next clock, so a `ser_clk` or `ser_lat` edge sampled at edge m changes the shift register or the register bank at edge m+2. The bench reference keeps a four-deep history of the sampled wire values and applies the same three-edge rule, without modelling flops. It compares every output 1 ns after each rising edge. One dedicated test checks the latch latency edge by edge, looking at the two edges before the commit and the one at which it lands. The OR with the pins is combinational, so it is checked in the same cycle in which the pins change.

// File: rtl/ctl3w_pkg.sv
package ctl3w_pkg;
  localparam int FRAME_W = 16;
  localparam int ADDR_W  = 2;
  localparam int PAY_W   = FRAME_W - ADDR_W;

  typedef enum logic [ADDR_W-1:0] {
    SEL_VOL_L = 2'b00,
    SEL_CTRL  = 2'b01,
    SEL_VOL_R = 2'b10,
    SEL_NONE  = 2'b11
  } sel_e;

  // field order is fixed by the bit positions the frame carries
  typedef struct packed {
    logic       x2;
    logic       x4;
    logic [1:0] wlen;
    logic       srst;
    logic       smute;
    logic [1:0] fmt;
    logic [1:0] demph;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  function automatic sel_e frame_sel(logic [FRAME_W-1:0] f);
    return sel_e'(f[ADDR_W-1:0]);
  endfunction

  function automatic logic [PAY_W-1:0] frame_pay(logic [FRAME_W-1:0] f);
    return f[FRAME_W-1:ADDR_W];
  endfunction

  function automatic ctrl_t pay_to_ctrl(logic [PAY_W-1:0] p);
    return ctrl_t'(p[CTRL_W-1:0]);
  endfunction
endpackage

// File: rtl/ctl3w_sync.sv
module ctl3w_sync #(
  parameter int W = 1,
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) st[i] <= '0;
    end else begin
      st[0] <= d;
      for (int i = 1; i < N; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[N-1];
endmodule

// File: rtl/ctl3w_edge.sv
module ctl3w_edge #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '0;
    else        prev <= lvl;
  end

  for (genvar g = 0; g < W; g++) begin : g_rise
    assign rise[g] = lvl[g] & ~prev[g];
  end
endmodule

// File: rtl/ctl3w_shift.sv
module ctl3w_shift
  import ctl3w_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_en,
  input  logic               din,
  output logic [FRAME_W-1:0] frame
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        frame <= '0;
    else if (shift_en) frame <= {frame[FRAME_W-2:0], din};
  end

  // the oldest bit leaves the top on every shift, so only the last 16 bits stay
  assert_shift_keeps_last_R10: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (frame[FRAME_W-1:1] == $past(frame[FRAME_W-2:0])) && (frame[0] == $past(din)));
endmodule

// File: rtl/ctl3w_bank.sv
module ctl3w_bank
  import ctl3w_pkg::*;
#(
  parameter logic [PAY_W-1:0] VOL_RST = '1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit,
  input  logic [FRAME_W-1:0] frame,
  output logic [PAY_W-1:0]   vol_l,
  output logic [PAY_W-1:0]   vol_r,
  output ctrl_t              ctrl
);
  sel_e             sel;
  logic [PAY_W-1:0] pay;

  assign sel = frame_sel(frame);
  assign pay = frame_pay(frame);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vol_l <= VOL_RST;
      vol_r <= VOL_RST;
      ctrl  <= '0;
    end else if (commit) begin
      unique case (sel)
        SEL_VOL_L: vol_l <= pay;
        SEL_VOL_R: vol_r <= pay;
        SEL_CTRL:  ctrl  <= pay_to_ctrl(pay);
        default:   ;
      endcase
    end
  end

  assert_left_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && sel == SEL_VOL_L) |=> (vol_l == $past(pay)) && $stable(vol_r) && $stable(ctrl));

  assert_right_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && sel == SEL_VOL_R) |=> (vol_r == $past(pay)) && $stable(vol_l) && $stable(ctrl));

  assert_ctrl_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && sel == SEL_CTRL) |=> (ctrl == $past(pay[CTRL_W-1:0])) && $stable(vol_l) && $stable(vol_r));

  assert_none_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && sel == SEL_NONE) |=> $stable(vol_l) && $stable(vol_r) && $stable(ctrl));

  assert_no_commit_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(vol_l) && $stable(vol_r) && $stable(ctrl));
endmodule

// File: rtl/ctl3w_regfile.sv
module ctl3w_regfile
  import ctl3w_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ser_clk,
  input  logic             ser_dat,
  input  logic             ser_lat,
  input  logic [1:0]       pin_fmt,
  input  logic             pin_mute,
  input  logic             pin_x4,
  input  logic             pin_x2,
  output logic [PAY_W-1:0] vol_l,
  output logic [PAY_W-1:0] vol_r,
  output logic [1:0]       demph_sel,
  output logic [1:0]       fmt_eff,
  output logic             mute_eff,
  output logic [1:0]       word_len,
  output logic             x4_eff,
  output logic             x2_eff,
  output logic             op_hold
);
  localparam int NWIRE = 3;

  logic [NWIRE-1:0]   raw_w, syn_w;
  logic [1:0]         strobes, strobe_rise;
  logic               bit_rise, lat_rise;
  logic [FRAME_W-1:0] frame;
  ctrl_t              ctrl;

  assign raw_w = {ser_lat, ser_dat, ser_clk};

  ctl3w_sync #(.W(NWIRE), .N(SYNC_N)) i_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_w), .q(syn_w)
  );

  assign strobes = {syn_w[2], syn_w[0]};

  ctl3w_edge #(.W(2)) i_edge (
    .clk(clk), .rst_n(rst_n), .lvl(strobes), .rise(strobe_rise)
  );

  assign bit_rise = strobe_rise[0];
  assign lat_rise = strobe_rise[1];

  ctl3w_shift i_shift (
    .clk(clk), .rst_n(rst_n), .shift_en(bit_rise), .din(syn_w[1]), .frame(frame)
  );

  ctl3w_bank i_bank (
    .clk(clk), .rst_n(rst_n), .commit(lat_rise), .frame(frame),
    .vol_l(vol_l), .vol_r(vol_r), .ctrl(ctrl)
  );

  assign demph_sel = ctrl.demph;
  assign word_len  = ctrl.wlen;
  assign op_hold   = ctrl.srst;
  assign fmt_eff   = ctrl.fmt | pin_fmt;
  assign mute_eff  = ctrl.smute | pin_mute;
  assign x4_eff    = ctrl.x4 | pin_x4;
  assign x2_eff    = ctrl.x2 | pin_x2;

  // soft reset only gates operation: the volumes move only on a commit
  assert_hold_keeps_vol_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_hold && !lat_rise) |=> $stable(vol_l) && $stable(vol_r) && op_hold);
endmodule

// File: tb/test_ctl3w_regfile.sv
`timescale 1ns/1ps
module test_ctl3w_regfile;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_lat = 1'b0;
  logic [1:0] pin_fmt = 2'b00;
  logic pin_mute = 1'b0, pin_x4 = 1'b0, pin_x2 = 1'b0;
  logic [13:0] vol_l, vol_r;
  logic [1:0] demph_sel, fmt_eff, word_len;
  logic mute_eff, x4_eff, x2_eff, op_hold;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  ctl3w_regfile i_ctl3w_regfile (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_lat(ser_lat),
    .pin_fmt(pin_fmt), .pin_mute(pin_mute), .pin_x4(pin_x4), .pin_x2(pin_x2),
    .vol_l(vol_l), .vol_r(vol_r), .demph_sel(demph_sel), .fmt_eff(fmt_eff),
    .mute_eff(mute_eff), .word_len(word_len), .x4_eff(x4_eff), .x2_eff(x2_eff),
    .op_hold(op_hold)
  );

  // reference: wire history, edges act two samples after they are seen
  int hc[$], hd[$], hl[$];
  logic [15:0] m_sh;
  logic [13:0] m_vl, m_vr;
  logic [9:0]  m_ctl;

  always @(posedge clk) begin
    if (!rst_n) begin
      hc.delete(); hd.delete(); hl.delete();
      m_sh = '0; m_vl = 14'h3FFF; m_vr = 14'h3FFF; m_ctl = '0;
    end else begin
      hc.push_back(int'(ser_clk)); hd.push_back(int'(ser_dat)); hl.push_back(int'(ser_lat));
      if (hc.size() > 4) begin
        void'(hc.pop_front()); void'(hd.pop_front()); void'(hl.pop_front());
      end
      if (hc.size() == 4) begin
        if (hl[1] == 1 && hl[0] == 0) begin
          case (m_sh[1:0])
            2'b00: m_vl = m_sh[15:2];
            2'b10: m_vr = m_sh[15:2];
            2'b01: m_ctl = m_sh[11:2];
            default: ;
          endcase
        end
        if (hc[1] == 1 && hc[0] == 0) m_sh = {m_sh[14:0], hd[1][0]};
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] pack_out();
    return {vol_l, vol_r, demph_sel, fmt_eff, mute_eff, word_len, x4_eff, x2_eff, op_hold};
  endfunction

  function automatic logic [63:0] pack_model();
    return {m_vl, m_vr, m_ctl[1:0], m_ctl[3:2] | pin_fmt, m_ctl[4] | pin_mute,
            m_ctl[7:6], m_ctl[8] | pin_x4, m_ctl[9] | pin_x2, m_ctl[5]};
  endfunction

  // per-clock comparison against the reference (cycle exactness, R9)
  always @(posedge clk) begin
    #1;
    if (rst_n && !finished) chk("R9 per-cycle model", pack_out(), pack_model());
  end

  task automatic send_bit(input logic b);
    @(negedge clk); ser_clk = 1'b0; ser_dat = b;
    repeat (2) @(negedge clk); ser_clk = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic send_bits(input logic [31:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
  endtask

  task automatic pulse_latch();
    @(negedge clk); ser_clk = 1'b0;
    repeat (5) @(negedge clk); ser_lat = 1'b1;
    repeat (3) @(negedge clk); ser_lat = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic write(input logic [15:0] f);
    send_bits({16'h0, f}, 16);
    pulse_latch();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: run did not complete actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 vol_l reset", 64'(vol_l), 64'h3FFF);
    chk("R1 vol_r reset", 64'(vol_r), 64'h3FFF);
    chk("R1 ctrl outputs reset",
        64'({demph_sel, fmt_eff, mute_eff, word_len, x4_eff, x2_eff, op_hold}), 64'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 left volume, address 00
    write({14'h1234, 2'b00});
    chk("R2 left volume", 64'(vol_l), 64'h1234);
    chk("R2 right untouched", 64'(vol_r), 64'h3FFF);

    // R3 right volume, address 10
    write({14'h2ABC, 2'b10});
    chk("R3 right volume", 64'(vol_r), 64'h2ABC);

    // R4 control fields: demph=10 fmt=01 mute=0 srst=0 wlen=10 x4=1 x2=0
    write({14'h0186, 2'b01});
    chk("R4 demph_sel", 64'(demph_sel), 64'h2);
    chk("R4 fmt", 64'(fmt_eff), 64'h1);
    chk("R4 word_len", 64'(word_len), 64'h2);
    chk("R4 x4/x2/mute/hold", 64'({x4_eff, x2_eff, mute_eff, op_hold}), 64'b1000);

    // R5 address 11 ignored
    write({14'h0000, 2'b11});
    chk("R5 vol_l unchanged", 64'(vol_l), 64'h1234);
    chk("R5 vol_r unchanged", 64'(vol_r), 64'h2ABC);
    chk("R5 ctrl unchanged", 64'({demph_sel, fmt_eff, word_len, x4_eff}), 64'b10_01_10_1);

    // R6 pins ORed with fields
    @(negedge clk); pin_fmt = 2'b10; pin_mute = 1'b1; pin_x2 = 1'b1;
    @(negedge clk);
    chk("R6 fmt OR", 64'(fmt_eff), 64'h3);
    chk("R6 mute OR", 64'(mute_eff), 64'h1);
    chk("R6 x2 OR", 64'(x2_eff), 64'h1);
    pin_fmt = 2'b00; pin_mute = 1'b0; pin_x2 = 1'b0;
    @(negedge clk);
    chk("R6 pins released", 64'({fmt_eff, mute_eff, x2_eff}), 64'b01_0_0);

    // R7 soft reset keeps contents
    write({14'h01A6, 2'b01});
    chk("R7 hold raised", 64'(op_hold), 64'h1);
    chk("R7 vol_l kept", 64'(vol_l), 64'h1234);
    chk("R7 fields kept", 64'({demph_sel, word_len, x4_eff}), 64'b10_10_1);
    write({14'h0186, 2'b01});
    chk("R7 hold released", 64'(op_hold), 64'h0);

    // R8 bits without latch
    send_bits({16'h0, 14'h0000, 2'b00}, 16);
    repeat (8) @(negedge clk);
    chk("R8 no latch no change", 64'(vol_l), 64'h1234);

    // R10 overlong frame: 4 leading junk bits then 16 real bits
    send_bits({12'h0, 4'hF, 14'h0055, 2'b00}, 20);
    pulse_latch();
    chk("R10 last 16 bits used", 64'(vol_l), 64'h0055);

    // R9 latency edge by edge
    send_bits({16'h0, 14'h0777, 2'b10}, 16);
    @(negedge clk); ser_clk = 1'b0;
    repeat (5) @(negedge clk); ser_lat = 1'b1;
    @(posedge clk); #1;
    chk("R9 edge 1 old", 64'(vol_r), 64'h2ABC);
    @(posedge clk); #1;
    chk("R9 edge 2 old", 64'(vol_r), 64'h2ABC);
    @(posedge clk); #1;
    chk("R9 edge 3 new", 64'(vol_r), 64'h0777);
    @(negedge clk); ser_lat = 1'b0;
    repeat (6) @(negedge clk);

    // R1 hardware reset after activity
    rst_n = 1'b0;
    #1;
    chk("R1 hw reset vol_l", 64'(vol_l), 64'h3FFF);
    chk("R1 hw reset vol_r", 64'(vol_r), 64'h3FFF);
    chk("R1 hw reset ctrl", 64'({demph_sel, fmt_eff, word_len, x4_eff, op_hold}), 64'h0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule